// File: doc/BRIEF.md
# Fractional Clock Source Mux Divider

This block picks one of several source clocks and divides it by a ratio made of an integer part and a binary fraction, giving one peripheral clock. It is built for a single fast core clock. Each source clock appears as a one-cycle strobe `src_tick[i]`, high for one core cycle per rising edge of that source. The divided clock leaves the block as the strobe `out_pulse`, one core cycle per output edge. Software sets the block up through two registers: a control register holding the enable and the source index, and a divide register holding the integer and fraction fields.

The fraction is handled by a phase accumulator. Every output period it adds the fraction to the accumulator. A carry out of the accumulator stretches the next period by one source tick, so over many periods the mean ratio is exact. Any register write stops the output for one cycle, connects the chosen source and restarts the divider with its phase cleared. A source change can therefore never produce a short or merged output period.

All pins are plain control and status pins. Nothing here is a stream, so there is no valid/ready handshake and no back-pressure: output strobes cannot be stalled, and a consumer that misses one loses that edge.

Top module: `frac_clk_div`

## Requirements
- R1: After reset both registers read zero and `out_pulse` is low.
- R2: Register 0 (control) holds the source index in bits [3:0] and the enable in bit 4. Register 1 (divide) holds the integer field in bits [12+INT_W-1:12] and the fraction in bits [11:12-FRAC_W]. Bits outside these fields are ignored on write and read as zero.
- R3: Bit 7 of the control register is read-only. It always reads the current value of the enable bit.
- R4: While enable is 0, `out_pulse` stays low.
- R5: Source 0 is ground and never produces an output. Source index i (1 to NSRC-1) is counted on `src_tick[i]`.
- R6: With fraction 0 and integer I > 0, one output pulse is produced for every I ticks of the selected source.
- R7: Phase starts at A = F, and the first period lasts max(I, 1) ticks. At each pulse the next period lasts I + c ticks (at least 1), where c is the carry of A + F over 2^FRAC_W, and A becomes the sum modulo 2^FRAC_W.
- R8: A divide value whose integer and fraction fields are both zero produces no output.
- R9: With I = 0 and F nonzero, every tick of the selected source gives an output pulse.
- R10: Any register write forces `out_pulse` low at the clock edge after that write's edge. From the edge after that, counting restarts from the selected source with the phase cleared.
- R11: When INT_W and FRAC_W are both 0, the enabled, non-ground source passes straight through to `out_pulse`. The divide register then reads zero.
- R12: An output pulse is registered. It appears at the same clock edge that samples the source tick which completes the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock |
| rst_n | input | 1 | active-low asynchronous reset |
| src_tick | input | NSRC | one strobe per source clock edge |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | 1 | write target: 0 control, 1 divide |
| wr_data | input | 32 | write data |
| rd_addr | input | 1 | read target: 0 control, 1 divide |
| rd_data | output | 32 | register read-back (combinational) |
| out_pulse | output | 1 | divided clock strobe |

## Verification
A tick driven before clock edge k shows on `out_pulse` right after edge k. The bench drives each input on a falling edge and compares at the next falling edge against a step-by-step reference computed from R6/R7.

A register write takes effect at its own edge. The following edge is always quiet, so the bench's configuration task checks the write edge against the old settings and the next two edges against zero before new counting begins. Read-back is combinational, so register values are compared a short delay after `rd_addr` is set.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  localparam int REG_W        = 32;
  // first bit of the integer field; the fraction sits directly below it
  localparam int INT_LSB      = 12;
  localparam int CTL_EN_BIT   = 4;
  localparam int CTL_BUSY_BIT = 7;
  localparam logic ADDR_CTL   = 1'b0;
  localparam logic ADDR_DIV   = 1'b1;
endpackage

// File: rtl/fcd_regs.sv
module fcd_regs
  import fcd_pkg::*;
#(
  parameter int SEL_W  = 4,
  parameter int INT_W  = 8,
  parameter int FRAC_W = 4,
  parameter int DW     = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_addr,
  output logic [REG_W-1:0] rd_data,
  output logic             en,
  output logic [SEL_W-1:0] sel,
  output logic [DW-1:0]    div_val,
  output logic             hold
);
  localparam int  DIV_LSB = INT_LSB - FRAC_W;
  localparam bit  HAS_DIV = (INT_W + FRAC_W) > 0;

  logic unused_wr_bits;
  assign unused_wr_bits = ^wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en      <= 1'b0;
      sel     <= '0;
      div_val <= '0;
      hold    <= 1'b0;
    end else begin
      hold <= wr_en;
      if (wr_en) begin
        if (wr_addr == ADDR_CTL) begin
          en  <= wr_data[CTL_EN_BIT];
          sel <= wr_data[SEL_W-1:0];
        end else if (HAS_DIV) begin
          div_val <= DW'(wr_data >> DIV_LSB);
        end
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_CTL) begin
      rd_data[SEL_W-1:0]   = sel;
      rd_data[CTL_EN_BIT]  = en;
      rd_data[CTL_BUSY_BIT] = en;
    end else begin
      rd_data = REG_W'(div_val) << DIV_LSB;
    end
  end
endmodule

// File: rtl/fcd_src_pick.sv
module fcd_src_pick #(
  parameter int NSRC  = 16,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic [SEL_W-1:0] sel,
  input  logic [NSRC-1:0]  src_tick,
  output logic [SEL_W-1:0] act_sel,
  output logic             sel_tick
);
  localparam int SLOTS = 1 << SEL_W;

  logic [SLOTS-1:0] slot_tick;
  logic             unused_gnd;

  // source 0 is ground; its input strobe is discarded
  assign unused_gnd = src_tick[0];

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    if (i == 0) begin : g_gnd
      assign slot_tick[i] = 1'b0;
    end else if (i < NSRC) begin : g_live
      assign slot_tick[i] = src_tick[i];
    end else begin : g_pad
      assign slot_tick[i] = 1'b0;
    end
  end

  // the connected source only moves during a quiet restart cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    act_sel <= '0;
    else if (hold) act_sel <= sel;
  end

  assign sel_tick = slot_tick[act_sel];
endmodule

// File: rtl/fcd_phase.sv
module fcd_phase #(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 4,
  parameter int DW     = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init,
  input  logic          sel_tick,
  input  logic [DW-1:0] div_val,
  output logic          out_pulse
);
  if (INT_W + FRAC_W == 0) begin : g_pass
    logic unused_div;
    assign unused_div = ^div_val;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_pulse <= 1'b0;
      else        out_pulse <= !init && sel_tick;
    end
  end else begin : g_frac
    localparam int IWX = (INT_W > 0) ? INT_W : 1;
    localparam int FWX = (FRAC_W > 0) ? FRAC_W : 1;
    localparam int CW  = IWX + 1;

    logic [IWX-1:0] int_p;
    logic [FWX-1:0] frac_p;
    logic [FWX-1:0] acc;
    logic [FWX:0]   sum;
    logic [CW-1:0]  cnt, len, nxt_len, first_len;
    logic           div_zero, last;

    if (INT_W > 0) begin : g_int
      assign int_p = div_val[DW-1 -: INT_W];
    end else begin : g_no_int
      assign int_p = '0;
    end

    if (FRAC_W > 0) begin : g_fr
      assign frac_p = div_val[FRAC_W-1:0];
    end else begin : g_no_fr
      assign frac_p = '0;
    end

    always_comb begin
      sum       = {1'b0, acc} + {1'b0, frac_p};
      nxt_len   = {1'b0, int_p} + CW'(sum[FWX]);
      if (nxt_len == '0) nxt_len = CW'(1);
      first_len = (int_p == '0) ? CW'(1) : {1'b0, int_p};
      div_zero  = (div_val == '0);
      last      = (cnt + CW'(1)) >= len;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt       <= '0;
        acc       <= '0;
        len       <= CW'(1);
        out_pulse <= 1'b0;
      end else if (init) begin
        cnt       <= '0;
        acc       <= frac_p;
        len       <= first_len;
        out_pulse <= 1'b0;
      end else begin
        out_pulse <= 1'b0;
        if (sel_tick && !div_zero) begin
          if (last) begin
            out_pulse <= 1'b1;
            cnt       <= '0;
            acc       <= sum[FWX-1:0];
            len       <= nxt_len;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
  import fcd_pkg::*;
#(
  parameter int NSRC   = 16,
  parameter int INT_W  = 8,
  parameter int FRAC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_tick,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_addr,
  output logic [REG_W-1:0] rd_data,
  output logic             out_pulse
);
  localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int DW    = (INT_W + FRAC_W > 0) ? (INT_W + FRAC_W) : 1;

  logic             en, hold, sel_tick, init;
  logic [SEL_W-1:0] sel, act_sel;
  logic [DW-1:0]    div_val;

  fcd_regs #(.SEL_W(SEL_W), .INT_W(INT_W), .FRAC_W(FRAC_W), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .en(en), .sel(sel), .div_val(div_val),
    .hold(hold)
  );

  fcd_src_pick #(.NSRC(NSRC), .SEL_W(SEL_W)) u_pick (
    .clk(clk), .rst_n(rst_n), .hold(hold), .sel(sel), .src_tick(src_tick),
    .act_sel(act_sel), .sel_tick(sel_tick)
  );

  // stop: disabled, or the cycle after any write (switch and restart)
  assign init = !en || hold;

  fcd_phase #(.INT_W(INT_W), .FRAC_W(FRAC_W), .DW(DW)) u_phase (
    .clk(clk), .rst_n(rst_n), .init(init), .sel_tick(sel_tick),
    .div_val(div_val), .out_pulse(out_pulse)
  );
endmodule

// File: rtl/frac_clk_div_chk.sv
module frac_clk_div_chk
  import fcd_pkg::*;
#(
  parameter int SEL_W = 4,
  parameter int DW    = 12,
  parameter bit PASS  = 1'b0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             rd_addr,
  input logic [REG_W-1:0] rd_data,
  input logic             out_pulse,
  input logic             en,
  input logic [SEL_W-1:0] act_sel,
  input logic             sel_tick,
  input logic [DW-1:0]    div_val
);
  // R3
  ctl_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == ADDR_CTL) |-> (rd_data[CTL_BUSY_BIT] == en));

  // R4
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !out_pulse);

  // R5
  ground_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_sel == '0) |=> !out_pulse);

  // R10
  restart_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ##2 !out_pulse);

  // R12
  pulse_has_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_pulse |-> $past(sel_tick));

  if (!PASS) begin : g_div
    // R8
    zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (div_val == '0) |=> !out_pulse);
  end
endmodule

bind frac_clk_div frac_clk_div_chk #(.SEL_W(SEL_W), .DW(DW), .PASS(INT_W + FRAC_W == 0)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_addr(rd_addr), .rd_data(rd_data),
  .out_pulse(out_pulse), .en(en), .act_sel(act_sel), .sel_tick(sel_tick),
  .div_val(div_val)
);

// File: tb/frac_clk_div_test.sv
`timescale 1ns/1ps
module frac_clk_div_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] src_tick;
  logic        wr_en, wr_addr, rd_addr;
  logic [31:0] wr_data;
  logic [31:0] rd_data, rd_pt;
  logic        out_pulse, out_pt;

  int n_cmp = 0, n_bad = 0;
  bit m_en;
  int m_sel, m_I, m_F, m_cnt, m_acc, m_len;

  always #2.5 clk = ~clk;

  frac_clk_div #(.NSRC(16), .INT_W(8), .FRAC_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .out_pulse(out_pulse)
  );

  frac_clk_div #(.NSRC(16), .INT_W(0), .FRAC_W(0)) uut_pt (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_pt), .out_pulse(out_pt)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int at_least_one(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  // reference for one clock edge, from R5..R9 and R11
  task automatic model_edge(input logic [15:0] t, output logic ef, output logic ep);
    int s;
    logic tk;
    tk = m_en && (m_sel != 0) && t[m_sel];
    ef = 1'b0;
    ep = tk;
    if (tk && (m_I != 0 || m_F != 0)) begin
      if (m_cnt + 1 >= m_len) begin
        ef    = 1'b1;
        m_cnt = 0;
        s     = m_acc + m_F;
        m_acc = s % 16;
        m_len = at_least_one(m_I + s / 16);
      end else begin
        m_cnt++;
      end
    end
  endtask

  task automatic step(input logic [15:0] t, input string tag);
    logic ef, ep;
    src_tick = t;
    @(posedge clk);
    model_edge(t, ef, ep);
    @(negedge clk);
    check(tag, {31'd0, out_pulse}, {31'd0, ef});
    check("R11 pass-through", {31'd0, out_pt}, {31'd0, ep});
  endtask

  task automatic wrr(input logic a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d; src_tick = '0;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic a, input logic [31:0] e, input logic [31:0] ept, input string tag);
    rd_addr = a;
    #1;
    check(tag, rd_data, e);
    check(tag, rd_pt, ept);
  endtask

  // R10: write edge uses old settings, the next two edges are quiet
  task automatic cfg(input bit en, input int sel, input int I, input int F,
                     input logic [15:0] t);
    logic ef, ep;
    wr_en = 1'b1; wr_addr = 1'b0; src_tick = t;
    wr_data = (en ? 32'h10 : 32'h0) | 32'(sel);
    @(posedge clk);
    model_edge(t, ef, ep);
    @(negedge clk);
    check("R10 write edge", {31'd0, out_pulse}, {31'd0, ef});
    check("R10 write edge pt", {31'd0, out_pt}, {31'd0, ep});
    m_en = en; m_sel = sel; m_I = I; m_F = F;
    m_cnt = 0; m_acc = F; m_len = at_least_one(I);
    wr_addr = 1'b1;
    wr_data = (32'(I) << 12) | (32'(F) << 8);
    @(posedge clk);
    @(negedge clk);
    check("R10 quiet 1", {31'd0, out_pulse}, 32'd0);
    check("R10 quiet 1 pt", {31'd0, out_pt}, 32'd0);
    wr_en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R10 quiet 2", {31'd0, out_pulse}, 32'd0);
    check("R10 quiet 2 pt", {31'd0, out_pt}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; src_tick = '0; wr_en = 1'b0; wr_addr = 1'b0; wr_data = '0; rd_addr = 1'b0;
    m_en = 0; m_sel = 0; m_I = 0; m_F = 0; m_cnt = 0; m_acc = 0; m_len = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1
    rd_chk(1'b0, 32'h0, 32'h0, "R1 ctl reset");
    rd_chk(1'b1, 32'h0, 32'h0, "R1 div reset");
    check("R1 out reset", {31'd0, out_pulse}, 32'd0);

    // R2 / R3
    wrr(1'b0, 32'hFFFF_FF35);
    rd_chk(1'b0, 32'h95, 32'h95, "R2 R3 ctl fields");
    wrr(1'b1, 32'hFFFF_FFFF);
    rd_chk(1'b1, 32'h000F_FF00, 32'h0, "R2 R11 div fields");
    wrr(1'b0, 32'h0000_0003);
    rd_chk(1'b0, 32'h03, 32'h03, "R3 busy clear");
    rd_addr = 1'b0;

    // R6
    cfg(1, 2, 3, 0, 16'h0);
    repeat (12) step(16'hFFFF, "R6 R12 integer");
    // R7
    cfg(1, 7, 2, 8, 16'h0);
    repeat (20) step(16'hFFFF, "R7 fraction");
    // R8
    cfg(1, 1, 0, 0, 16'h0);
    repeat (8) step(16'hFFFF, "R8 zero divisor");
    // R9
    cfg(1, 3, 0, 5, 16'h0);
    repeat (8) step(16'hFFFF, "R9 int zero");
    // R5
    cfg(1, 0, 1, 0, 16'h0);
    repeat (8) step(16'hFFFF, "R5 ground");
    // R4
    cfg(0, 4, 1, 0, 16'h0);
    repeat (8) step(16'hFFFF, "R4 disabled");
    rd_chk(1'b0, 32'h04, 32'h04, "R3 busy off");
    // R10: phase cleared by a rewrite mid-period
    cfg(1, 1, 4, 0, 16'h0);
    repeat (2) step(16'hFFFF, "R10 before");
    cfg(1, 1, 4, 0, 16'hFFFF);
    repeat (10) step(16'hFFFF, "R10 after");

    // constrained random
    for (int k = 0; k < 40; k++) begin
      bit en;
      int sel, I, F, dens;
      en   = ($urandom % 8) != 0;
      sel  = $urandom % 16;
      I    = $urandom % 6;
      F    = $urandom % 16;
      dens = $urandom % 3;
      cfg(en, sel, I, F, 16'($urandom));
      for (int j = 0; j < 120; j++) begin
        logic [15:0] t;
        t = 16'($urandom);
        if (dens == 0) t = 16'hFFFF;
        if (dens == 1) t = t & 16'($urandom);
        step(t, "R5 R7 R12 random");
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule